// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when the temperature sensor of a temperature-compensated oscillator takes a reading. A free-running interval counter, advanced by a slow tick enable, requests an automatic conversion once per interval. Software can also ask for a conversion by writing 1 to a self-clearing convert bit. The convert bit stays high while that conversion runs and clears when it completes.

A single sequencer handles both kinds of request. It starts one conversion at a time. It raises a busy status bit immediately for automatic conversions. For software conversions, busy rises only after a programmable number of ticks. When the sensor reports completion, the block captures the 10-bit temperature code (0.25 °C per LSB) and pulses an update strobe so the compensation logic loads the new value.

An automatic request that falls due while another conversion is running is held back. It starts as soon as that conversion ends. The interval schedule never moves because of software requests.

Top module: `tconv_sched`

## Requirements
- R1: After a synchronous active-low reset, these outputs are all 0: `conv_bit`, `busy_bit`, `sns_start`, `comp_upd` and `temp_code`.
- R2: While idle, an automatic conversion starts on the interval boundary. `sns_start` pulses in the second cycle after the clock edge that samples the `PERIOD_TICKS`-th tick since the previous boundary.
- R3: A write with `cfg_wr_en`=1 and `cfg_wr_conv`=1, while idle and with no automatic request pending, has two effects in the next cycle: `sns_start` pulses and `conv_bit` reads 1.
- R4: `conv_bit` stays 1 until the sensor reports done. In the cycle after done is sampled, both `conv_bit` and `busy_bit` read 0.
- R5: During a software conversion, `busy_bit` stays 0 until `BUSY_DLY_TICKS` ticks have been sampled after the start. It reads 1 from the cycle after the edge that samples the last of those ticks.
- R6: A write of 1 while a conversion runs is ignored: no new `sns_start` pulse, `conv_bit` keeps its value, and nothing is remembered for later. A write of 0 never changes `conv_bit`.
- R7: When done is sampled during a conversion, `temp_code` takes `sns_result` and `comp_upd` pulses, both in the next cycle. `temp_code` holds between updates. A done while idle is ignored.
- R8: During an automatic conversion, `busy_bit` is 1 from the `sns_start` cycle until completion, and `conv_bit` stays 0.
- R9: An automatic request that falls due during an active conversion starts in the cycle directly after that conversion's `comp_upd` pulse.
- R10: The interval counter counts every tick regardless of software conversions, so a software start never shifts the next automatic boundary.
- R11: `sns_start` is high for exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Slow time-base enable, one cycle per tick |
| cfg_wr_en | input | 1 | Register write strobe for the convert bit |
| cfg_wr_conv | input | 1 | Value written to the convert bit |
| sns_done | input | 1 | Sensor reports conversion finished |
| sns_result | input | 10 | Sensor temperature code, valid with `sns_done` |
| sns_start | output | 1 | One-cycle pulse starting a sensor conversion |
| conv_bit | output | 1 | Convert bit read-back |
| busy_bit | output | 1 | Busy status bit |
| temp_code | output | 10 | Latched temperature code, 0.25 °C per LSB |
| comp_upd | output | 1 | One-cycle strobe to the compensation logic |

## Verification
The main function is driven with five patterns:
- A software request with no ticks at all, which separates the convert bit from the delayed busy bit.
- A software request with ticks, which locates the exact cycle busy rises.
- A purely periodic boundary reached from idle.
- A software request started mid-interval, with the boundary falling during it. This shows whether the periodic request is deferred or dropped, and whether the user start moved the schedule.
- Repeated writes during a running conversion, and a stray done while idle, which show that neither leaves any trace.

A scoreboard compares every latched code, including the all-ones code, against the order in which the sensor produced them.

// File: rtl/tconv_pkg.sv
// Package: shared types and widths for the temperature conversion scheduler.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package tconv_pkg;

    // Width of the sensor temperature code (0.25 degC per LSB).
    localparam int unsigned TEMP_CODE_W = 10;

    // Sequencer state: idle, running an automatic conversion, or a software one.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_AUTO = 2'd1,
        SEQ_USER = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tconv_interval.sv
// Module: tconv_interval
// Counts tick enables and raises a pending automatic-conversion request on
// every PERIOD_TICKS-th tick. The counter never restarts except at reset,
// so software conversions cannot shift the schedule. The request stays
// pending until the sequencer takes it.
// Assumes: PERIOD_TICKS >= 2; take_i is only asserted while pend_o is 1.
module tconv_interval #(
    parameter int unsigned PERIOD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic take_i,
    output logic pend_o
);

    localparam int unsigned CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             due;

    // Boundary reached on this tick.
    assign due = tick_en && (cnt_q == LAST);

    // Free-running interval counter, wraps on the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= due ? '0 : cnt_q + 1'b1;
        end
    end

    // Pending request: set on the boundary, cleared when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !take_i) || due;
        end
    end

    assign pend_o = pend_q;

    // R9: a pending request is never dropped, only taken
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(take_i));

    // R10: the counter moves only on ticks
    cnt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_en) && $past(rst_n) |-> $stable(cnt_q));

endmodule

// File: rtl/tconv_seq.sv
// Module: tconv_seq
// Conversion sequencer. Starts one conversion at a time, giving a pending
// automatic request priority over a software write in the same cycle. Keeps
// the convert bit for software conversions and the busy bit for both kinds;
// for software conversions busy rises only after BUSY_DLY_TICKS ticks.
// Assumes: BUSY_DLY_TICKS >= 1; done_i is only meaningful while running.
module tconv_seq
    import tconv_pkg::*;
#(
    parameter int unsigned BUSY_DLY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wr_en,
    input  logic wr_conv,
    input  logic pend_i,
    input  logic done_i,
    output logic take_o,
    output logic start_o,
    output logic conv_o,
    output logic busy_o,
    output logic finish_o
);

    localparam int unsigned DLY_W = (BUSY_DLY_TICKS > 1) ? $clog2(BUSY_DLY_TICKS + 1) : 1;
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(BUSY_DLY_TICKS - 1);

    seq_state_e       state_q;
    logic             conv_q;
    logic             busy_q;
    logic             start_q;
    logic [DLY_W-1:0] dly_q;
    logic             idle;
    logic             user_go;
    logic             dly_hit;

    // Request decode: automatic first, software only when nothing is pending.
    always_comb begin
        idle     = (state_q == SEQ_IDLE);
        take_o   = idle && pend_i;
        user_go  = idle && !pend_i && wr_en && wr_conv;
        finish_o = !idle && done_i;
        dly_hit  = (state_q == SEQ_USER) && tick_en && !busy_q && (dly_q == DLY_LAST);
    end

    // One-cycle start pulse towards the sensor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= take_o || user_go;
        end
    end

    // State, convert bit and busy bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            conv_q  <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (take_o) begin
                        state_q <= SEQ_AUTO;
                        busy_q  <= 1'b1;
                    end else if (user_go) begin
                        state_q <= SEQ_USER;
                        conv_q  <= 1'b1;
                    end
                end
                SEQ_AUTO: begin
                    if (done_i) begin
                        state_q <= SEQ_IDLE;
                        busy_q  <= 1'b0;
                    end
                end
                SEQ_USER: begin
                    if (done_i) begin
                        state_q <= SEQ_IDLE;
                        conv_q  <= 1'b0;
                        busy_q  <= 1'b0;
                    end else if (dly_hit) begin
                        busy_q  <= 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    conv_q  <= 1'b0;
                    busy_q  <= 1'b0;
                end
            endcase
        end
    end

    // Tick counter for the delayed busy of software conversions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (user_go) begin
            dly_q <= '0;
        end else if ((state_q == SEQ_USER) && tick_en && !busy_q && !dly_hit) begin
            dly_q <= dly_q + 1'b1;
        end
    end

    assign start_o = start_q;
    assign conv_o  = conv_q;
    assign busy_o  = busy_q;

    // R11: start is a single-cycle pulse
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R3: convert bit rises together with a start pulse
    conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_q) |-> start_q);

    // R8: an automatic start raises busy with the start pulse
    auto_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) && !conv_q |-> start_q);

    // R8: automatic and software conversions never overlap
    kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_AUTO) |-> !conv_q);

endmodule

// File: rtl/tconv_result.sv
// Module: tconv_result
// Captures the sensor code on an accepted completion and raises a
// one-cycle update strobe for the compensation logic in the same cycle
// as the new code appears.
// Assumes: finish_i is already qualified by an active conversion.
module tconv_result #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish_i,
    input  logic [CODE_W-1:0] result_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);

    logic [CODE_W-1:0] code_q;
    logic              upd_q;

    // Result latch and update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= finish_i;
            if (finish_i) begin
                code_q <= result_i;
            end
        end
    end

    assign code_o = code_q;
    assign upd_o  = upd_q;

    // R7: code changes only together with the update strobe
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |-> $stable(code_q));

    // R7: update strobe lasts one cycle
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q);

endmodule

// File: rtl/tconv_sched.sv
// Module: tconv_sched (top)
// Temperature conversion scheduler: periodic interval counter, conversion
// sequencer and result latch. The periods are counted in tick enables.
// Assumes: the sensor asserts sns_done for one cycle, at some point after
// sns_start, with sns_result valid in that cycle.
module tconv_sched
    import tconv_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS   = 64,
    parameter int unsigned BUSY_DLY_TICKS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   cfg_wr_en,
    input  logic                   cfg_wr_conv,
    input  logic                   sns_done,
    input  logic [TEMP_CODE_W-1:0] sns_result,
    output logic                   sns_start,
    output logic                   conv_bit,
    output logic                   busy_bit,
    output logic [TEMP_CODE_W-1:0] temp_code,
    output logic                   comp_upd
);

    logic pend;
    logic take;
    logic finish;

    tconv_interval #(
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .take_i  (take),
        .pend_o  (pend)
    );

    tconv_seq #(
        .BUSY_DLY_TICKS(BUSY_DLY_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_en    (cfg_wr_en),
        .wr_conv  (cfg_wr_conv),
        .pend_i   (pend),
        .done_i   (sns_done),
        .take_o   (take),
        .start_o  (sns_start),
        .conv_o   (conv_bit),
        .busy_o   (busy_bit),
        .finish_o (finish)
    );

    tconv_result #(
        .CODE_W(TEMP_CODE_W)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish_i (finish),
        .result_i (sns_result),
        .code_o   (temp_code),
        .upd_o    (comp_upd)
    );

    // R4: the convert bit clears only with the completion strobe
    conv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_bit) |-> comp_upd);

    // R4: after completion both status bits are low
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comp_upd |-> !conv_bit && !busy_bit);

endmodule

// File: tb/tconv_sched_tb.sv
// Testbench for tconv_sched: a sensor model pushes each produced code into
// a scoreboard queue and a monitor pops it when comp_upd appears.
module tconv_sched_tb;

    localparam int unsigned PER = 8;
    localparam int unsigned DLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic       cfg_wr_conv = 1'b0;
    logic       sns_done = 1'b0;
    logic [9:0] sns_result = '0;
    logic       sns_start;
    logic       conv_bit;
    logic       busy_bit;
    logic [9:0] temp_code;
    logic       comp_upd;

    int         n_chk = 0;
    int         n_fail = 0;
    int         lat = 20;
    int         k_res = 0;
    bit         finished = 1'b0;
    logic [9:0] exp_q[$];
    logic [9:0] last_code = '0;

    always #10 clk = ~clk;

    tconv_sched #(.PERIOD_TICKS(PER), .BUSY_DLY_TICKS(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_conv(cfg_wr_conv),
        .sns_done(sns_done), .sns_result(sns_result),
        .sns_start(sns_start), .conv_bit(conv_bit), .busy_bit(busy_bit),
        .temp_code(temp_code), .comp_upd(comp_upd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic write_conv(input logic v);
        cfg_wr_en = 1'b1;
        cfg_wr_conv = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wr_conv = 1'b0;
    endtask

    task automatic wait_upd();
        do @(negedge clk); while (!comp_upd);
    endtask

    // Sensor model: answers each start after lat cycles, pushes expected code.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sns_start) begin
                automatic int l = lat;
                automatic logic [9:0] v = (k_res == 0) ? 10'h3FF : 10'((k_res * 157 + 3) % 1024);
                repeat (l - 1) @(negedge clk);
                sns_done = 1'b1;
                sns_result = v;
                exp_q.push_back(v);
                k_res++;
                @(negedge clk);
                sns_done = 1'b0;
                sns_result = '0;
            end
        end
    end

    // Monitor: pops the scoreboard on each update strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && comp_upd) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected update", 1, 0);
                end else begin
                    automatic logic [9:0] e = exp_q.pop_front();
                    chk(temp_code == e, "R7 latched code", int'(temp_code), int'(e));
                    last_code = e;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!conv_bit && !busy_bit && !sns_start && !comp_upd && temp_code == 0,
            "R1 reset outputs", int'({conv_bit, busy_bit, sns_start, comp_upd}), 0);

        // Software conversion without ticks: busy must stay low (R3, R5, R4)
        lat = 20;
        write_conv(1'b1);
        chk(sns_start && conv_bit, "R3 start and convert bit", int'({sns_start, conv_bit}), 3);
        chk(!busy_bit, "R5 busy delayed", int'(busy_bit), 0);
        repeat (5) @(negedge clk);
        chk(conv_bit && !busy_bit, "R5 no ticks keeps busy low", int'({conv_bit, busy_bit}), 2);
        wait_upd();
        chk(!conv_bit && !busy_bit, "R4 cleared at completion", int'({conv_bit, busy_bit}), 0);

        // Software conversion with ticks: busy after DLY ticks (R5), ticks 1..3
        repeat (2) @(negedge clk);
        write_conv(1'b1);
        tick();
        tick();
        chk(!busy_bit && conv_bit, "R5 busy low before delay", int'({conv_bit, busy_bit}), 2);
        tick();
        chk(busy_bit && conv_bit, "R5 busy after delay", int'({conv_bit, busy_bit}), 3);
        wait_upd();
        chk(!conv_bit && !busy_bit, "R4 both cleared", int'({conv_bit, busy_bit}), 0);

        // Writes during a conversion are ignored (R6, R11)
        repeat (2) @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_conv = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wr_conv = 1'b0;
        chk(!sns_start && conv_bit, "R11 R6 single start, bit kept", int'({sns_start, conv_bit}), 1);
        write_conv(1'b0);
        chk(conv_bit, "R6 write of 0 ignored", int'(conv_bit), 1);
        wait_upd();
        @(negedge clk);
        chk(!sns_start && !conv_bit, "R6 ignored write not remembered", int'({sns_start, conv_bit}), 0);

        // Periodic boundary from idle: ticks 4..8 (R2, R8, R10)
        lat = 4;
        repeat (4) tick();
        @(negedge clk);
        chk(!sns_start && !busy_bit, "R2 no start before boundary", int'({sns_start, busy_bit}), 0);
        tick();
        chk(!sns_start, "R2 start not yet", int'(sns_start), 0);
        @(negedge clk);
        chk(sns_start && busy_bit && !conv_bit, "R2 R8 automatic start",
            int'({sns_start, busy_bit, conv_bit}), 6);
        write_conv(1'b1);
        chk(!conv_bit && busy_bit, "R6 R8 write during automatic run", int'({conv_bit, busy_bit}), 1);
        wait_upd();
        chk(!busy_bit, "R8 busy cleared", int'(busy_bit), 0);

        // Deferred periodic request, schedule unshifted (R9, R10): ticks 9..16
        repeat (3) tick();
        lat = 40;
        write_conv(1'b1);
        repeat (5) tick();
        chk(busy_bit && conv_bit, "R5 busy during software run", int'({conv_bit, busy_bit}), 3);
        lat = 4;
        wait_upd();
        @(negedge clk);
        chk(sns_start && busy_bit && !conv_bit, "R9 R10 deferred automatic start",
            int'({sns_start, busy_bit, conv_bit}), 6);
        wait_upd();

        // Next boundary exactly PER ticks later: ticks 17..24 (R2)
        repeat (PER - 1) tick();
        @(negedge clk);
        chk(!sns_start && !busy_bit, "R2 no early start", int'({sns_start, busy_bit}), 0);
        tick();
        @(negedge clk);
        chk(sns_start && busy_bit, "R2 next boundary", int'({sns_start, busy_bit}), 3);
        wait_upd();

        // Done while idle is ignored (R7)
        repeat (2) @(negedge clk);
        sns_done = 1'b1;
        sns_result = 10'h2AA;
        @(negedge clk);
        sns_done = 1'b0;
        sns_result = '0;
        @(negedge clk);
        chk(!comp_upd && temp_code == last_code, "R7 idle done ignored",
            int'(temp_code), int'(last_code));
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule